// File: doc/BRIEF.md
# Masked DMA Request Scanner

This block decides which DMA channel is served next in a system of two controllers with four channels each. Each channel has a latched request bit. A hardware hold event sets the bit, a hardware release event clears it, and a software request write can set or clear it as well. Each controller also has a four-bit mask register and a disable input. A channel is eligible when its request bit is set, its mask bit is clear and its controller is not disabled.

The block does not scan all the time. A scan pass starts only after a trigger: a mask write, a software request write, or a hold or release event. A pass visits the global channel indices in ascending order, one index per clock. When the index under the scan is eligible, the pass grants that channel and holds the grant until the channel engine reports that its burst is complete. The pass then moves on to the next index. If a pass granted any channel, or if a trigger arrived while it was running, a new pass starts when it ends. As a result, transfers continue for as long as requests stay active.

The reset is asynchronous and active low. Its deassertion is expected to be synchronised to the clock upstream of this block.

Top module: `dma_req_scanner`

## Requirements
- R1: Global channel n belongs to controller n/4 and is local channel n mod 4 there. Grant bit n of `grant_o` serves global channel n, and bit c of every per-controller input vector selects controller c.
- R2: A pulse on `hold_i[n]` sets the request of channel n and a pulse on `release_i[n]` clears it. If both arrive in the same cycle, the request ends up clear.
- R3: When `sw_req_we[c]` is high, the request of local channel `sw_req_data[1:0]` on controller c is set if `sw_req_data[2]` is 1 and cleared if it is 0.
- R4: A channel is granted only when its request is set and its mask bit is 0. A `mask_we[c]` pulse loads `mask_data` into the mask of controller c, and a mask bit of 1 blocks the channel.
- R5: Within a pass, eligible channels are granted in ascending global order, from controller 0 channels 0 to 3 through controller 1 channels 0 to 3.
- R6: At most one bit of `grant_o` is high at any time. A grant holds until `burst_done_i` is sampled high, and it drops in the following cycle.
- R7: A pass starts only after a mask write, a software request write, or a hold or release event. When the scanner is idle and a hold on an eligible channel 0 is sampled at edge k, the grant appears after edge k+2. A change on `ctrl_disable_i` alone starts no pass.
- R8: A pass that granted any channel is followed by a new pass, so a channel whose request stays set is granted again.
- R9: While `ctrl_disable_i[c]` is high, controller c receives no new grant.
- R10: After reset, `grant_o` is 0, all requests are clear and all mask bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 8 | Per-channel hold events that set the request |
| release_i | input | 8 | Per-channel release events that clear the request |
| sw_req_we | input | 2 | Software request write strobe, one per controller |
| sw_req_data | input | 3 | Bit 2 selects set (1) or clear (0); bits 1:0 give the local channel |
| mask_we | input | 2 | Mask write strobe, one per controller |
| mask_data | input | 4 | New mask value, where 1 blocks the local channel |
| ctrl_disable_i | input | 2 | Per-controller disable, which blocks all of that controller's grants |
| burst_done_i | input | 1 | The channel engine has finished the granted burst |
| grant_o | output | 8 | One-hot service grant, indexed by global channel |

## Verification
The bench drives pairs of channels across both controllers and expects the lower-numbered channel to be granted first. A design that ignored the controller boundary or walked indices in the wrong order would grant them the other way round. A lone persistent request must be granted a second time, which exposes a scanner that never starts a new pass. A release that lands during a grant must end service, and a release that arrives together with a hold must leave the request clear. Two further cases catch a scanner that runs on its own: a disable change that is not paired with a trigger must produce nothing, and the exact two-cycle latency from a hold to its grant must hold.

// File: rtl/dma_scan_pkg.sv
package dma_scan_pkg;
  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_WALK  = 2'd1,
    SC_SERVE = 2'd2
  } scan_state_e;
endpackage

// File: rtl/dma_req_bank.sv
module dma_req_bank #(
  parameter int CH = 4,
  localparam int LW = $clog2(CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] hold_i,
  input  logic [CH-1:0] release_i,
  input  logic          sw_we,
  input  logic          sw_set,
  input  logic [LW-1:0] sw_sel,
  input  logic          mask_we,
  input  logic [CH-1:0] mask_d,
  input  logic          ctrl_off,
  output logic [CH-1:0] eligible_o
);
  logic [CH-1:0] req_q, req_n;
  logic [CH-1:0] mask_q;
  logic          req_en;

  // Precedence: software write first, then hold sets, release clears last
  always_comb begin
    req_n = req_q;
    if (sw_we) req_n[sw_sel] = sw_set;
    req_n = req_n | hold_i;
    req_n = req_n & ~release_i;
  end

  assign req_en = sw_we | (|hold_i) | (|release_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      mask_q <= '1;
    end else begin
      if (req_en)  req_q  <= req_n;
      if (mask_we) mask_q <= mask_d;
    end
  end

  assign eligible_o = ctrl_off ? '0 : (req_q & ~mask_q);
endmodule

// File: rtl/dma_scan_fsm.sv
module dma_scan_fsm
  import dma_scan_pkg::*;
#(
  parameter int NCH = 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trig_i,
  input  logic [NCH-1:0] eligible_i,
  input  logic           done_i,
  output logic [NCH-1:0] grant_o
);
  scan_state_e   st_q, st_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          svc_q, svc_n;
  logic          pend_q, pend_n;
  logic          step;
  logic          last;

  assign last = (idx_q == IW'(NCH - 1));

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    svc_n  = svc_q;
    pend_n = pend_q | trig_i;
    step   = 1'b0;
    case (st_q)
      SC_IDLE: begin
        if (pend_q) begin
          st_n   = SC_WALK;
          idx_n  = '0;
          svc_n  = 1'b0;
          pend_n = trig_i;
        end
      end
      SC_WALK: begin
        if (eligible_i[idx_q]) begin
          st_n  = SC_SERVE;
          svc_n = 1'b1;
        end else begin
          step = 1'b1;
        end
      end
      SC_SERVE: begin
        if (done_i) step = 1'b1;
      end
      default: st_n = SC_IDLE;
    endcase
    if (step) begin
      if (last) begin
        if (svc_q || pend_q) begin
          st_n   = SC_WALK;
          idx_n  = '0;
          svc_n  = 1'b0;
          pend_n = trig_i;
        end else begin
          st_n = SC_IDLE;
        end
      end else begin
        st_n  = SC_WALK;
        idx_n = idx_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SC_IDLE;
      idx_q  <= '0;
      svc_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      svc_q  <= svc_n;
      pend_q <= pend_n;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_grant
    assign grant_o[g] = (st_q == SC_SERVE) && (idx_q == IW'(g));
  end
endmodule

// File: rtl/dma_req_scanner.sv
module dma_req_scanner #(
  parameter int NCTRL = 2,
  parameter int CH = 4,
  localparam int NCH = NCTRL * CH,
  localparam int LW = $clog2(CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   hold_i,
  input  logic [NCH-1:0]   release_i,
  input  logic [NCTRL-1:0] sw_req_we,
  input  logic [LW:0]      sw_req_data,
  input  logic [NCTRL-1:0] mask_we,
  input  logic [CH-1:0]    mask_data,
  input  logic [NCTRL-1:0] ctrl_disable_i,
  input  logic             burst_done_i,
  output logic [NCH-1:0]   grant_o
);
  logic [NCH-1:0] eligible;
  logic           trig;

  assign trig = (|hold_i) | (|release_i) | (|sw_req_we) | (|mask_we);

  for (genvar c = 0; c < NCTRL; c++) begin : g_ctrl
    dma_req_bank #(.CH(CH)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_i     (hold_i[c*CH +: CH]),
      .release_i  (release_i[c*CH +: CH]),
      .sw_we      (sw_req_we[c]),
      .sw_set     (sw_req_data[LW]),
      .sw_sel     (sw_req_data[LW-1:0]),
      .mask_we    (mask_we[c]),
      .mask_d     (mask_data),
      .ctrl_off   (ctrl_disable_i[c]),
      .eligible_o (eligible[c*CH +: CH])
    );
  end

  dma_scan_fsm #(.NCH(NCH)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig),
    .eligible_i (eligible),
    .done_i     (burst_done_i),
    .grant_o    (grant_o)
  );
endmodule

// File: rtl/dma_req_scanner_chk.sv
module dma_req_scanner_chk #(
  parameter int NCTRL = 2,
  parameter int CH = 4,
  localparam int NCH = NCTRL * CH
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCTRL-1:0] ctrl_disable_i,
  input logic             burst_done_i,
  input logic [NCH-1:0]   grant_o
);
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_grant_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && !burst_done_i) |=> (grant_o == $past(grant_o)));

  p_grant_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && burst_done_i) |=> (grant_o == '0));

  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (grant_o == '0));

  for (genvar c = 0; c < NCTRL; c++) begin : g_dis
    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant_o[c*CH +: CH] != '0) && ($past(grant_o) == '0))
        |-> !$past(ctrl_disable_i[c]));
  end
endmodule

bind dma_req_scanner dma_req_scanner_chk #(.NCTRL(NCTRL), .CH(CH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctrl_disable_i (ctrl_disable_i),
  .burst_done_i   (burst_done_i),
  .grant_o        (grant_o)
);

// File: tb/sim_dma_req_scanner.sv
module sim_dma_req_scanner;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] hold_i, release_i;
  logic [1:0] sw_req_we, mask_we, ctrl_disable_i;
  logic [2:0] sw_req_data;
  logic [3:0] mask_data;
  logic       burst_done_i;
  logic [7:0] grant_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_req_scanner u0 (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .release_i(release_i),
    .sw_req_we(sw_req_we), .sw_req_data(sw_req_data), .mask_we(mask_we),
    .mask_data(mask_data), .ctrl_disable_i(ctrl_disable_i),
    .burst_done_i(burst_done_i), .grant_o(grant_o)
  );

  // {mask1, mask0, disable, hold, first grant, second grant}
  localparam logic [33:0] VEC [8] = '{
    {4'h0, 4'h0, 2'b00, 8'h01, 8'h01, 8'h01},  // R8 rescan of lone channel
    {4'h0, 4'h0, 2'b00, 8'h90, 8'h10, 8'h80},  // R1 R5 controller 1 order
    {4'h0, 4'hF, 2'b00, 8'h21, 8'h20, 8'h20},  // R4 controller 0 masked
    {4'h0, 4'h4, 2'b00, 8'h0C, 8'h08, 8'h08},  // R4 single bit mask
    {4'h0, 4'h0, 2'b01, 8'h11, 8'h10, 8'h10},  // R9 controller 0 disabled
    {4'h0, 4'h0, 2'b11, 8'hFF, 8'h00, 8'h00},  // R9 both disabled
    {4'hF, 4'hF, 2'b00, 8'hFF, 8'h00, 8'h00},  // R10 masks all set
    {4'h0, 4'h0, 2'b00, 8'h06, 8'h02, 8'h04}   // R5 ascending order
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: grant actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    hold_i = '0; release_i = '0; sw_req_we = '0; sw_req_data = '0;
    mask_we = '0; mask_data = '0; ctrl_disable_i = '0; burst_done_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_mask(input int c, input logic [3:0] v);
    mask_we[c] = 1'b1; mask_data = v;
    @(negedge clk);
    mask_we = '0;
  endtask

  task automatic pulse_hold(input logic [7:0] v);
    hold_i = v;
    @(negedge clk);
    hold_i = '0;
  endtask

  task automatic wait_grant(output logic [7:0] g);
    for (int i = 0; i < 40; i++) begin
      if (grant_o != '0) break;
      @(negedge clk);
    end
    g = grant_o;
  endtask

  task automatic end_burst();
    burst_done_i = 1'b1;
    @(negedge clk);
    burst_done_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] g;
    // R10 reset state
    do_reset();
    chk("R10 reset grant", grant_o, 8'h00);
    wait_grant(g);
    chk("R10 no grant after reset", g, 8'h00);

    // Vector table
    for (int v = 0; v < 8; v++) begin
      do_reset();
      ctrl_disable_i = VEC[v][25:24];
      wr_mask(0, VEC[v][29:26]);
      wr_mask(1, VEC[v][33:30]);
      pulse_hold(VEC[v][23:16]);
      wait_grant(g);
      chk("R5 vector first grant", g, VEC[v][15:8]);
      if (g != '0) end_burst();
      wait_grant(g);
      chk("R8 vector second grant", g, VEC[v][7:0]);
      if (g != '0) end_burst();
    end

    // R7 exact latency from hold to grant
    do_reset();
    wr_mask(0, 4'h0);
    repeat (12) @(negedge clk);
    pulse_hold(8'h01);
    chk("R7 after edge k", grant_o, 8'h00);
    @(negedge clk);
    chk("R7 after edge k+1", grant_o, 8'h00);
    @(negedge clk);
    chk("R7 after edge k+2", grant_o, 8'h01);
    // R6 grant held while burst runs
    repeat (5) @(negedge clk);
    chk("R6 grant held", grant_o, 8'h01);
    end_burst();
    chk("R6 grant dropped after done", grant_o, 8'h00);

    // R2 release during grant ends service
    do_reset();
    wr_mask(0, 4'h0);
    pulse_hold(8'h08);
    wait_grant(g);
    chk("R2 grant ch3", g, 8'h08);
    release_i = 8'h08;
    @(negedge clk);
    release_i = '0;
    end_burst();
    wait_grant(g);
    chk("R2 released channel not granted", g, 8'h00);

    // R2 hold and release together leave request clear
    do_reset();
    wr_mask(0, 4'h0);
    hold_i = 8'h02; release_i = 8'h02;
    @(negedge clk);
    hold_i = '0; release_i = '0;
    wait_grant(g);
    chk("R2 simultaneous hold release", g, 8'h00);

    // R3 software set then clear on controller 1 local 2
    do_reset();
    wr_mask(1, 4'h0);
    sw_req_we = 2'b10; sw_req_data = 3'b110;
    @(negedge clk);
    sw_req_we = '0;
    wait_grant(g);
    chk("R3 software set grants ch6", g, 8'h40);
    sw_req_we = 2'b10; sw_req_data = 3'b010;
    @(negedge clk);
    sw_req_we = '0;
    end_burst();
    wait_grant(g);
    chk("R3 software clear stops ch6", g, 8'h00);

    // R7 disable change alone starts no pass; a mask write does
    do_reset();
    ctrl_disable_i = 2'b01;
    wr_mask(0, 4'h0);
    pulse_hold(8'h01);
    repeat (15) @(negedge clk);
    ctrl_disable_i = 2'b00;
    wait_grant(g);
    chk("R7 no pass without trigger", g, 8'h00);
    wr_mask(0, 4'h0);
    wait_grant(g);
    chk("R7 mask write starts pass", g, 8'h01);
    end_burst();

    // R4 mask write blocks pending request
    do_reset();
    pulse_hold(8'h02);
    wait_grant(g);
    chk("R4 masked at reset", g, 8'h00);
    wr_mask(0, 4'h0);
    wait_grant(g);
    chk("R4 unmask grants ch1", g, 8'h02);
    end_burst();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule